// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Delivery and Acknowledge

This block stands between the interrupt sources of a controller and one processor. It tracks two sets over all sources: a pending set of sources that have been offered to the processor and not yet taken, and an in-service set of sources that the processor has acknowledged but not yet retired. It also holds the processor's current task priority. A source is only delivered when its priority is above the task priority. Delivery is also withheld when a source of higher priority is already pending, or when a source of equal or higher priority is being serviced.

Source configuration lives outside the block. The block reads each source's priority, vector, trigger sense, active bit and critical-route bit from flat input buses. It tells the source side when to set or clear an active bit through one-hot request vectors. The processor takes an interrupt with an acknowledge strobe, which returns a vector one cycle later. It retires the interrupt with an end-of-interrupt strobe. A stale pending entry is answered with a programmable spurious vector. An entry is stale when its source went inactive, or when its priority no longer beats the task priority.

Top module: `prio_deliver`

## Requirements
- R1: The task priority register is 4 bits, resets to 0xF and loads `tp_wdata` when `tp_we` is high. An offer whose source priority is less than or equal to the task priority is rejected: no `act_set` pulse, no pending entry and no output change.
- R2: An offer for a source that is already pending is dropped. It produces no `act_set` pulse and leaves the pending set unchanged.
- R3: An accepted offer pulses `act_set` at the offered index in the same cycle and adds the source to the pending set. The interrupt output rises on the next clock unless an already pending source has a strictly higher priority, or an in-service source has a priority greater than or equal to the offered one.
- R4: When the top entry of a set is chosen, the highest priority wins, and among equal priorities the lowest source index wins. An empty set counts as priority 0.
- R5: An acknowledge lowers both interrupt outputs on the next clock and raises `ack_valid` for exactly that cycle. If nothing is pending, `ack_vec` is the spurious vector. This vector resets to 0xFF and loads `spur_wdata` when `spur_we` is high.
- R6: If the top pending source is inactive (`src_active` low), or its priority is not above the task priority, the acknowledge pulses `act_clr` for it and returns the spurious vector.
- R7: Otherwise the acknowledge moves the top pending source into the in-service set and returns its vector. The pending bit is always cleared on acknowledge. An edge-sensitive source (`src_level` bit 0) also gets an `act_clr` pulse.
- R8: An end-of-interrupt removes the top in-service entry. If a pending source then has a priority above the top remaining in-service priority, the interrupt output rises again on the next clock.
- R9: When `crit_en` is high and the delivered source's `src_crit` bit is set, `cirq_out` rises instead of `irq_out`. Otherwise `irq_out` rises.
- R10: An end-of-interrupt in the same cycle as an acknowledge is ignored. An offer in the same cycle as an acknowledge or end-of-interrupt is judged against the sets as they stood before that cycle. A rise caused in a cycle wins over the lowering caused by an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | Offer strobe for one source |
| offer_idx | input | IDX_W | Index of the offered source |
| src_prio | input | NSRC*PRIO_W | Source i priority in bits [i*4 +: 4] |
| src_vec | input | NSRC*VEC_W | Source i vector in bits [i*8 +: 8] |
| src_level | input | NSRC | 1 = level-sensitive, 0 = edge-sensitive |
| src_active | input | NSRC | Active bit of each source |
| src_crit | input | NSRC | Critical-route bit of each source for this CPU |
| crit_en | input | 1 | Enables critical routing |
| tp_we | input | 1 | Task priority write strobe |
| tp_wdata | input | PRIO_W | Task priority write data |
| spur_we | input | 1 | Spurious vector write strobe |
| spur_wdata | input | VEC_W | Spurious vector write data |
| ack_req | input | 1 | Acknowledge read strobe |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| irq_out | output | 1 | Normal interrupt line |
| cirq_out | output | 1 | Critical interrupt line |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | VEC_W | Acknowledge result vector |
| act_set | output | NSRC | One-hot request to set a source active bit |
| act_clr | output | NSRC | One-hot request to clear a source active bit |

## Verification
An offer can land in the same cycle as an acknowledge or an end-of-interrupt. Then the acceptance test, the selection of the top entry and the output update all read the same starting state. The random phase draws these strobes independently, so offers together with acknowledges, and acknowledges together with end-of-interrupts, arise often. Directed cycles also force both pairs. Each cycle is judged against a bench model that evaluates the pre-cycle sets, applies the R10 precedence, and then compares the active-bit requests, both interrupt lines and the acknowledge vector.

// File: rtl/prio_deliver.sv
module prio_deliver #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    offer_valid,
  input  logic [$clog2(NSRC)-1:0] offer_idx,
  input  logic [NSRC*PRIO_W-1:0]  src_prio,
  input  logic [NSRC*VEC_W-1:0]   src_vec,
  input  logic [NSRC-1:0]         src_level,
  input  logic [NSRC-1:0]         src_active,
  input  logic [NSRC-1:0]         src_crit,
  input  logic                    crit_en,
  input  logic                    tp_we,
  input  logic [PRIO_W-1:0]       tp_wdata,
  input  logic                    spur_we,
  input  logic [VEC_W-1:0]        spur_wdata,
  input  logic                    ack_req,
  input  logic                    eoi_req,
  output logic                    irq_out,
  output logic                    cirq_out,
  output logic                    ack_valid,
  output logic [VEC_W-1:0]        ack_vec,
  output logic [NSRC-1:0]         act_set,
  output logic [NSRC-1:0]         act_clr
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]   raised_q, srv_q, srv_rem;
  logic [PRIO_W-1:0] tp_q;
  logic [VEC_W-1:0]  spur_q;

  function automatic logic [PRIO_W-1:0] top_pr(input logic [NSRC-1:0] m, input logic [NSRC*PRIO_W-1:0] pr);
    logic [PRIO_W-1:0] best;
    logic found;
    best = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (m[i] && (!found || pr[i*PRIO_W +: PRIO_W] > best)) begin
        best = pr[i*PRIO_W +: PRIO_W];
        found = 1'b1;
      end
    return best;
  endfunction

  function automatic logic [IDX_W-1:0] top_idx(input logic [NSRC-1:0] m, input logic [NSRC*PRIO_W-1:0] pr);
    logic [PRIO_W-1:0] best;
    logic [IDX_W-1:0]  idx;
    logic found;
    best = '0;
    idx = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (m[i] && (!found || pr[i*PRIO_W +: PRIO_W] > best)) begin
        best = pr[i*PRIO_W +: PRIO_W];
        idx = IDX_W'(i);
        found = 1'b1;
      end
    return idx;
  endfunction

  logic [IDX_W-1:0]  r_idx, s_idx;
  logic [PRIO_W-1:0] r_pr, s_pr, s2_pr, o_pr;
  logic              r_any, s_any;

  assign r_any = |raised_q;
  assign s_any = |srv_q;
  assign r_idx = top_idx(raised_q, src_prio);
  assign r_pr  = top_pr(raised_q, src_prio);
  assign s_idx = top_idx(srv_q, src_prio);
  assign s_pr  = top_pr(srv_q, src_prio);

  logic eoi_go;
  assign eoi_go  = eoi_req && !ack_req;
  assign srv_rem = srv_q & ~((eoi_go && s_any) ? (NSRC'(1) << s_idx) : '0);
  assign s2_pr   = top_pr(srv_rem, src_prio);

  assign o_pr = src_prio[offer_idx*PRIO_W +: PRIO_W];

  logic o_take, o_fire, o_crit, a_hit, a_ok, e_fire, e_crit;
  assign o_take = offer_valid && (o_pr > tp_q) && !raised_q[offer_idx];
  assign o_fire = o_take && (o_pr >= r_pr) && (o_pr > s_pr);
  assign o_crit = crit_en && src_crit[offer_idx];
  assign a_hit  = ack_req && r_any;
  assign a_ok   = a_hit && src_active[r_idx] && (r_pr > tp_q);
  assign e_fire = eoi_go && r_any && (r_pr > s2_pr);
  assign e_crit = crit_en && src_crit[r_idx];

  logic [NSRC-1:0] r_bit;
  assign r_bit   = NSRC'(1) << r_idx;
  assign act_set = o_take ? (NSRC'(1) << offer_idx) : '0;
  assign act_clr = (a_hit && (!a_ok || !src_level[r_idx])) ? r_bit : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised_q  <= '0;
      srv_q     <= '0;
      tp_q      <= '1;
      spur_q    <= '1;
      irq_out   <= 1'b0;
      cirq_out  <= 1'b0;
      ack_valid <= 1'b0;
      ack_vec   <= '0;
    end else begin
      raised_q  <= (raised_q | act_set) & ~(a_hit ? r_bit : '0);
      srv_q     <= srv_rem | (a_ok ? r_bit : '0);
      irq_out   <= (irq_out & ~ack_req) | (o_fire & ~o_crit) | (e_fire & ~e_crit);
      cirq_out  <= (cirq_out & ~ack_req) | (o_fire & o_crit) | (e_fire & e_crit);
      ack_valid <= ack_req;
      if (ack_req) ack_vec <= a_ok ? src_vec[r_idx*VEC_W +: VEC_W] : spur_q;
      if (tp_we)   tp_q   <= tp_wdata;
      if (spur_we) spur_q <= spur_wdata;
    end
  end
endmodule

// File: rtl/prio_deliver_chk.sv
module prio_deliver_chk #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    offer_valid,
  input logic [$clog2(NSRC)-1:0] offer_idx,
  input logic [NSRC*PRIO_W-1:0]  src_prio,
  input logic [PRIO_W-1:0]       tp_q,
  input logic                    ack_req,
  input logic                    ack_valid,
  input logic                    crit_en,
  input logic                    cirq_out,
  input logic [NSRC-1:0]         act_set,
  input logic [NSRC-1:0]         act_clr
);
  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act_set)); // R3
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act_clr)); // R7
  AST_SET_CLR_APART: assert property (@(posedge clk) disable iff (!rst_n) (act_set & act_clr) == '0); // R6
  AST_LOW_PRIO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && src_prio[offer_idx*PRIO_W +: PRIO_W] <= tp_q) |-> act_set == '0); // R1
  AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n) ack_req |=> ack_valid); // R5
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !ack_req |=> !ack_valid); // R5
  AST_CRIT_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!crit_en && !cirq_out) |=> !cirq_out); // R9
endmodule

bind prio_deliver prio_deliver_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_idx(offer_idx),
  .src_prio(src_prio), .tp_q(tp_q), .ack_req(ack_req), .ack_valid(ack_valid),
  .crit_en(crit_en), .cirq_out(cirq_out), .act_set(act_set), .act_clr(act_clr)
);

// File: tb/prio_deliver_tb.sv
module prio_deliver_tb;
  localparam int NSRC = 16, PW = 4, VW = 8, IW = 4;

  logic clk = 0, rst_n = 0;
  logic offer_valid = 0, crit_en = 0, tp_we = 0, spur_we = 0, ack_req = 0, eoi_req = 0;
  logic [IW-1:0] offer_idx = '0;
  logic [NSRC*PW-1:0] src_prio = '0;
  logic [NSRC*VW-1:0] src_vec = '0;
  logic [NSRC-1:0] src_level = '0, src_active = '0, src_crit = '0;
  logic [PW-1:0] tp_wdata = '0;
  logic [VW-1:0] spur_wdata = '0;
  logic irq_out, cirq_out, ack_valid;
  logic [VW-1:0] ack_vec;
  logic [NSRC-1:0] act_set, act_clr;

  always #10 clk = ~clk;

  prio_deliver u_dut (.*);

  int checks = 0, errors = 0;
  logic [NSRC-1:0] m_raised = '0, m_srv = '0, m_act = '0;
  logic [PW-1:0] m_tp = 4'hF;
  logic [VW-1:0] m_spur = 8'hFF, m_vec = '0;
  logic m_irq = 0, m_cirq = 0, m_ackv = 0;

  function automatic logic [PW-1:0] pr_of(input int i);
    return src_prio[i*PW +: PW];
  endfunction

  function automatic int b_top(input logic [NSRC-1:0] m);
    int best = -1;
    for (int i = 0; i < NSRC; i++)
      if (m[i] && (best < 0 || pr_of(i) > pr_of(best))) best = i;
    return best;
  endfunction

  function automatic logic [PW-1:0] b_pr(input logic [NSRC-1:0] m);
    int t = b_top(m);
    return (t < 0) ? '0 : pr_of(t);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input string req);
    logic [NSRC-1:0] e_set, e_clr, rem;
    logic take, fire, ahit, aok, eg, efire, oc, ec;
    int ri, si;
    logic [PW-1:0] opr, rpr, spr, s2;
    opr = pr_of(int'(offer_idx));
    ri = b_top(m_raised); rpr = b_pr(m_raised);
    si = b_top(m_srv);    spr = b_pr(m_srv);
    take = offer_valid && opr > m_tp && !m_raised[offer_idx];
    fire = take && opr >= rpr && opr > spr;
    oc = crit_en && src_crit[offer_idx];
    ahit = ack_req && ri >= 0;
    aok = ahit && m_act[ri] && rpr > m_tp;
    eg = eoi_req && !ack_req;
    rem = m_srv;
    if (eg && si >= 0) rem[si] = 1'b0;
    s2 = b_pr(rem);
    efire = eg && ri >= 0 && rpr > s2;
    ec = (ri >= 0) && crit_en && src_crit[ri];
    e_set = take ? (NSRC'(1) << offer_idx) : '0;
    e_clr = (ahit && (!aok || !src_level[ri])) ? (NSRC'(1) << ri) : '0;
    #2;
    chk(req, "act_set", 32'(act_set), 32'(e_set));
    chk(req, "act_clr", 32'(act_clr), 32'(e_clr));
    @(posedge clk);
    m_raised = m_raised | e_set;
    if (ahit) m_raised[ri] = 1'b0;
    m_srv = rem;
    if (aok) m_srv[ri] = 1'b1;
    m_irq  = (m_irq && !ack_req) || (fire && !oc) || (efire && !ec);
    m_cirq = (m_cirq && !ack_req) || (fire && oc) || (efire && ec);
    m_ackv = ack_req;
    if (ack_req) m_vec = aok ? src_vec[ri*VW +: VW] : m_spur;
    if (tp_we) m_tp = tp_wdata;
    if (spur_we) m_spur = spur_wdata;
    m_act = (m_act | e_set) & ~e_clr;
    #1;
    chk(req, "irq_out", 32'(irq_out), 32'(m_irq));
    chk(req, "cirq_out", 32'(cirq_out), 32'(m_cirq));
    chk(req, "ack_valid", 32'(ack_valid), 32'(m_ackv));
    if (m_ackv) chk(req, "ack_vec", 32'(ack_vec), 32'(m_vec));
    @(negedge clk);
    offer_valid = 0; ack_req = 0; eoi_req = 0; tp_we = 0; spur_we = 0;
    src_active = m_act;
  endtask

  task automatic offer(input int i, input string req);
    offer_valid = 1; offer_idx = IW'(i); tick(req);
  endtask

  task automatic set_src(input int i, input logic [PW-1:0] p, input logic [VW-1:0] v, input logic lvl);
    src_prio[i*PW +: PW] = p; src_vec[i*VW +: VW] = v; src_level[i] = lvl;
  endtask

  initial begin
    #(20*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int i = 0; i < NSRC; i++) set_src(i, PW'(i % 8 + 1), VW'(8'h40 + i), 1'b0);
    repeat (3) @(negedge clk);
    chk("R5", "reset irq_out", 32'(irq_out), 0);
    chk("R5", "reset cirq_out", 32'(cirq_out), 0);
    chk("R5", "reset ack_valid", 32'(ack_valid), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: reset task priority 0xF rejects even priority 15
    set_src(3, 4'hF, 8'h33, 1'b0);
    offer(3, "R1");
    // R5: empty acknowledge returns reset spurious 0xFF
    ack_req = 1; tick("R5");
    tp_we = 1; tp_wdata = 4'h2; tick("R1");
    set_src(4, 4'h2, 8'h44, 1'b0);
    offer(4, "R1");
    set_src(3, 4'h3, 8'h33, 1'b0);
    offer(3, "R3");
    offer(3, "R2");
    ack_req = 1; tick("R7");
    spur_we = 1; spur_wdata = 8'h3C; tick("R5");
    ack_req = 1; tick("R5");
    // R4: equal priorities, lowest index wins; in-service 3 has prio 3
    set_src(5, 4'h6, 8'h55, 1'b1);
    set_src(2, 4'h6, 8'h22, 1'b1);
    offer(5, "R3");
    offer(2, "R4");
    offer(5, "R2");
    ack_req = 1; tick("R4");
    // R8: EOI retires source 2, source 5 re-raises
    eoi_req = 1; tick("R8");
    // R6: source 5 went inactive
    m_act[5] = 1'b0; src_active = m_act;
    ack_req = 1; tick("R6");
    // R6: priority dropped to task priority
    set_src(6, 4'h5, 8'h66, 1'b1);
    offer(6, "R3");
    tp_we = 1; tp_wdata = 4'h5; tick("R1");
    ack_req = 1; tick("R6");
    eoi_req = 1; tick("R8");
    // R9: critical routing
    crit_en = 1; src_crit[7] = 1'b1; set_src(7, 4'h9, 8'h77, 1'b0);
    offer(7, "R9");
    ack_req = 1; tick("R9");
    src_crit[7] = 1'b0; set_src(8, 4'hA, 8'h88, 1'b0);
    eoi_req = 1; tick("R8");
    offer(8, "R9");
    // R10: offer with acknowledge, then acknowledge with EOI
    set_src(9, 4'hC, 8'h99, 1'b0);
    offer_valid = 1; offer_idx = 4'd9; ack_req = 1; tick("R10");
    ack_req = 1; eoi_req = 1; tick("R10");
    eoi_req = 1; offer_valid = 1; offer_idx = 4'd10; set_src(10, 4'hD, 8'hAA, 1'b0); tick("R10");
    repeat (3) begin eoi_req = 1; tick("R8"); end

    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) begin
        for (int i = 0; i < NSRC; i++) set_src(i, PW'($urandom), VW'($urandom), 1'($urandom));
        src_crit = NSRC'($urandom);
        crit_en = 1'($urandom);
      end
      offer_valid = ($urandom % 10) < 4;
      offer_idx = IW'($urandom);
      ack_req = ($urandom % 10) < 2;
      eoi_req = ($urandom % 100) < 15;
      tp_we = ($urandom % 100) < 5;
      tp_wdata = PW'($urandom % 8);
      spur_we = ($urandom % 100) < 3;
      spur_wdata = VW'($urandom);
      if (($urandom % 100) < 5) begin
        int k = int'($urandom % NSRC);
        if (src_level[k]) begin m_act[k] = 1'b0; src_active = m_act; end
      end
      tick("R3,R4,R6,R7,R8,R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule